// File: doc/BRIEF.md
# Received Byte Pair Swap Unit

This block sits between the read side of a serial-bus controller and a local byte-addressed sensor-data buffer. It takes the bytes read back from one external device and writes each one into the buffer. For each transfer, three settings can be chosen: a swap enable, a pairing phase and a byte count. When swapping is on, the bytes that make up each two-byte word trade places before they are stored. The pairing phase sets where a word begins. Words can start on even positions (0–1, 2–3, …) or on odd positions (1–2, 3–4, …). A byte that has no partner is stored as it is.

A one-cycle start pulse opens a transaction. In that same cycle the unit latches the settings and a base offset. Bytes then arrive with a valid strobe, and each one takes the next position from 0 up to count−1. Any byte that arrives after the count is reached is dropped.

The buffer side is a two-lane write port. Lane 0 writes `buf_addr` and lane 1 writes `buf_addr+1`, so both bytes of a swapped word are written in one cycle. To do this, the unit holds the first byte of a word until the second byte arrives.

Top module: `byte_pair_swap`

## Requirements
- R1: With swap on and pairing phase 0, the bytes at positions 2k and 2k+1 are both written in the cycle after the byte at 2k+1 arrives. The byte at 2k+1 goes to base+2k and the byte at 2k goes to base+2k+1.
- R2: With swap on and pairing phase 1, positions 2k−1 and 2k (k ≥ 1) form a word. Its bytes are stored exchanged in the same way.
- R3: With swap off, each accepted byte at position p is written to base+p on lane 0 alone, in the cycle after it arrives.
- R4: With swap on, a byte without a partner is written unswapped to base+p on lane 0 alone, in the cycle after it arrives. Examples are position 0 under phase 1, or a last position that would start a word.
- R5: Bytes that arrive once the count has been reached cause no write. A count of 0 writes nothing.
- R6: A start pulse sets the position back to 0 and drops any held byte. A byte that arrives with the start pulse is position 0 of the new transaction.
- R7: `buf_we` bit 0 enables lane 0 (`buf_wdata[7:0]` to `buf_addr`). Bit 1 enables lane 1 (`buf_wdata[15:8]` to `buf_addr+1`). Addresses wrap modulo the address width. Bit 1 is set only for a swapped word, and then together with bit 0.
- R8: Swap, phase, count and base are sampled only on the start pulse. Changes to them during a transaction have no effect.
- R9: During reset, and after reset before the first start pulse, `buf_we` is 0 and incoming bytes are ignored.
- R10: Each position from 0 to count−1 of a fully delivered transaction is written exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Start-of-transaction pulse; latches the settings |
| rx_valid | input | 1 | Qualifies `rx_byte` |
| rx_byte | input | 8 | Received byte |
| cfg_swap | input | 1 | Exchange the bytes of each word |
| cfg_odd_grp | input | 1 | Pairing phase: 0 even-first, 1 odd-first |
| cfg_len | input | 4 | Number of bytes in the transaction, 0–15 |
| cfg_base | input | 8 | Buffer offset of position 0 |
| buf_we | output | 2 | Lane write enables (bit 0 lane 0, bit 1 lane 1) |
| buf_addr | output | 8 | Buffer address of lane 0 |
| buf_wdata | output | 16 | Lane 1 data in the high byte, lane 0 data in the low byte |

## Verification
The bench covers both pairing phases with even and odd counts. A trailing or leading unpartnered byte shows whether it is stored unswapped, or whether a faulty design holds it forever or pairs it with garbage. Transactions are restarted in the middle of a held word, and a byte is sent in the same cycle as the start pulse. A design that leaks the held byte, or that counts that byte as position 1, writes the wrong addresses. Surplus bytes, a count of 0, settings changed mid-transfer and a base near the top of the address range check that no write escapes the window and that addresses wrap. Every cycle is compared against a behavioural model, and the buffer image of each transaction is compared against the permutation the requirements define.

// File: rtl/bps_pkg.sv
package bps_pkg;
  // Role of the current byte in a word
  typedef enum logic [1:0] {
    K_SINGLE = 2'd0,  // stored directly at its own position
    K_HOLD   = 2'd1,  // first byte of a word, kept until its partner arrives
    K_PAIR   = 2'd2   // second byte of a word, completes the swap
  } kind_e;
endpackage

// File: rtl/bps_rst_sync.sv
module bps_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bps_pos_tracker.sv
module bps_pos_tracker #(
  parameter int LEN_W  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              valid,
  input  logic              in_swap,
  input  logic              in_odd,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [ADDR_W-1:0] in_base,
  output logic              accept,
  output logic [LEN_W-1:0]  pos,
  output logic              swap,
  output logic              odd,
  output logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] base
);
  logic [LEN_W-1:0]  pos_q, pos_d, len_q;
  logic [ADDR_W-1:0] base_q;
  logic              swap_q, odd_q;
  logic              pos_ld;

  // Effective settings for this cycle: the start pulse takes the new ones at once
  always_comb begin
    swap   = start ? in_swap : swap_q;
    odd    = start ? in_odd  : odd_q;
    len    = start ? in_len  : len_q;
    base   = start ? in_base : base_q;
    pos    = start ? '0      : pos_q;
    accept = valid && (pos < len);
    pos_d  = accept ? pos + 1'b1 : pos;
    pos_ld = start || accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      len_q  <= '0;
      base_q <= '0;
      swap_q <= 1'b0;
      odd_q  <= 1'b0;
    end else begin
      if (pos_ld) pos_q <= pos_d;
      if (start) begin
        len_q  <= in_len;
        base_q <= in_base;
        swap_q <= in_swap;
        odd_q  <= in_odd;
      end
    end
  end

  // The position never passes the latched count (R5)
  assert_pos_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= len_q);

  // A start pulse puts the position back at 0, or 1 if a byte came with it (R6)
  assert_start_rewinds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pos_q <= 1));

  // Settings hold still between start pulses (R8)
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (len_q == $past(len_q)) && (base_q == $past(base_q)));
endmodule

// File: rtl/bps_pair_classifier.sv
module bps_pair_classifier #(
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap,
  input  logic              odd,
  input  logic [LEN_W-1:0]  pos,
  input  logic [LEN_W-1:0]  len,
  output bps_pkg::kind_e    kind
);
  import bps_pkg::*;

  logic           lead_slot;
  logic           has_next;
  logic [LEN_W:0] pos_nx;

  always_comb begin
    pos_nx    = {1'b0, pos} + 1'b1;
    lead_slot = (pos[0] == odd);
    has_next  = pos_nx < {1'b0, len};
    if (!swap)                      kind = K_SINGLE;
    else if (lead_slot && has_next) kind = K_HOLD;
    else if (!lead_slot && (pos != '0)) kind = K_PAIR;
    else                            kind = K_SINGLE;
  end

  // Bytes are only held or paired while swapping is on (R3)
  assert_no_pairing_unswapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != K_SINGLE) |-> swap);
endmodule

// File: rtl/bps_swap_writer.sv
module bps_swap_writer #(
  parameter int LEN_W  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                accept,
  input  bps_pkg::kind_e      kind,
  input  logic [DATA_W-1:0]   din,
  input  logic [LEN_W-1:0]    pos,
  input  logic [ADDR_W-1:0]   base,
  output logic [1:0]          we,
  output logic [ADDR_W-1:0]   addr,
  output logic [2*DATA_W-1:0] wdata
);
  import bps_pkg::*;

  logic [DATA_W-1:0]   hold_q;
  logic                hold_vld_q, hold_vld_d;
  logic                hold_ld;
  logic [1:0]          we_d;
  logic [ADDR_W-1:0]   addr_d, pos_addr;
  logic [2*DATA_W-1:0] wdata_d;

  always_comb begin
    pos_addr = base + ADDR_W'(pos);
    hold_ld  = accept && (kind == K_HOLD);
    we_d     = 2'b00;
    addr_d   = pos_addr;
    wdata_d  = {{DATA_W{1'b0}}, din};
    if (accept) begin
      unique case (kind)
        K_PAIR: begin
          we_d    = 2'b11;
          addr_d  = pos_addr - 1'b1;
          wdata_d = {hold_q, din};
        end
        K_SINGLE: we_d = 2'b01;
        default:  we_d = 2'b00;
      endcase
    end
    if (hold_ld)                                 hold_vld_d = 1'b1;
    else if (start || (accept && kind == K_PAIR)) hold_vld_d = 1'b0;
    else                                         hold_vld_d = hold_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      we         <= 2'b00;
      addr       <= '0;
      wdata      <= '0;
    end else begin
      hold_vld_q <= hold_vld_d;
      we         <= we_d;
      if (hold_ld) hold_q <= din;
      if (accept) begin
        addr  <= addr_d;
        wdata <= wdata_d;
      end
    end
  end

  // A word completes only over a byte held in this transaction (R6)
  assert_pair_has_partner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_PAIR) |-> hold_vld_q);

  // A completed word drives both lanes in the next cycle (R7)
  assert_pair_both_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_PAIR) |=> (we == 2'b11));

  // No write without an accepted byte (R5)
  assert_no_write_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (we == 2'b00));
endmodule

// File: rtl/byte_pair_swap.sv
module byte_pair_swap #(
  parameter int LEN_W  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                txn_start,
  input  logic                rx_valid,
  input  logic [DATA_W-1:0]   rx_byte,
  input  logic                cfg_swap,
  input  logic                cfg_odd_grp,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [ADDR_W-1:0]   cfg_base,
  output logic [1:0]          buf_we,
  output logic [ADDR_W-1:0]   buf_addr,
  output logic [2*DATA_W-1:0] buf_wdata
);
  import bps_pkg::*;

  logic              rst_n_s;
  logic              accept, swap, odd;
  logic [LEN_W-1:0]  pos, len;
  logic [ADDR_W-1:0] base;
  kind_e             kind;

  bps_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  bps_pos_tracker #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_trk (
    .clk(clk), .rst_n(rst_n_s), .start(txn_start), .valid(rx_valid),
    .in_swap(cfg_swap), .in_odd(cfg_odd_grp), .in_len(cfg_len), .in_base(cfg_base),
    .accept(accept), .pos(pos), .swap(swap), .odd(odd), .len(len), .base(base)
  );

  bps_pair_classifier #(.LEN_W(LEN_W)) u_cls (
    .clk(clk), .rst_n(rst_n_s), .swap(swap), .odd(odd), .pos(pos), .len(len),
    .kind(kind)
  );

  bps_swap_writer #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n_s), .start(txn_start), .accept(accept), .kind(kind),
    .din(rx_byte), .pos(pos), .base(base),
    .we(buf_we), .addr(buf_addr), .wdata(buf_wdata)
  );

  // Lane 1 never writes alone (R7)
  assert_lane1_with_lane0_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    buf_we[1] |-> buf_we[0]);
endmodule

// File: tb/test_byte_pair_swap.sv
module test_byte_pair_swap;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        txn_start, rx_valid, cfg_swap, cfg_odd_grp;
  logic [7:0]  rx_byte, cfg_base;
  logic [3:0]  cfg_len;
  logic [1:0]  buf_we;
  logic [7:0]  buf_addr;
  logic [15:0] buf_wdata;

  int errors = 0;
  int checks = 0;
  string req;

  // behavioural model state
  int m_pos, m_len, m_base, m_swap, m_grp;
  int m_held;
  logic [1:0]  e_we;
  logic [7:0]  e_addr;
  logic [15:0] e_data;

  logic [7:0] img [256];
  int         cnt [256];
  logic [7:0] src [16];

  always #2.5 clk = ~clk;

  byte_pair_swap i_byte_pair_swap (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .cfg_swap(cfg_swap), .cfg_odd_grp(cfg_odd_grp),
    .cfg_len(cfg_len), .cfg_base(cfg_base),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive, predict, wait one cycle, compare.
  task automatic step(input bit s, input bit v, input logic [7:0] b);
    int p;
    txn_start = s; rx_valid = v; rx_byte = b;
    e_we = 2'b00; e_addr = 8'h00; e_data = 16'h0000;
    if (s) begin
      m_pos = 0; m_len = cfg_len; m_base = cfg_base;
      m_swap = cfg_swap; m_grp = cfg_odd_grp;
    end
    if (v && m_pos < m_len) begin
      p = m_pos;
      m_pos++;
      if (m_swap == 0) begin
        e_we = 2'b01; e_addr = 8'(m_base + p); e_data = {8'h00, b};
      end else if ((p % 2) == m_grp && p + 1 < m_len) begin
        m_held = b;
      end else if ((p % 2) != m_grp && p > 0) begin
        e_we = 2'b11; e_addr = 8'(m_base + p - 1); e_data = {8'(m_held), b};
      end else begin
        e_we = 2'b01; e_addr = 8'(m_base + p); e_data = {8'h00, b};
      end
    end
    @(negedge clk);
    txn_start = 1'b0; rx_valid = 1'b0;
    check(buf_we === e_we, "write enables", buf_we, e_we);
    if (e_we != 2'b00) begin
      check(buf_addr === e_addr, "address", buf_addr, e_addr);
      check(buf_wdata[7:0] === e_data[7:0], "lane0 data", buf_wdata[7:0], e_data[7:0]);
      if (e_we[1])
        check(buf_wdata[15:8] === e_data[15:8], "lane1 data", buf_wdata[15:8], e_data[15:8]);
    end
    if (buf_we[0]) begin img[buf_addr] = buf_wdata[7:0]; cnt[buf_addr]++; end
    if (buf_we[1]) begin img[8'(buf_addr + 1)] = buf_wdata[15:8]; cnt[8'(buf_addr + 1)]++; end
  endtask

  // Expected image: position p holds its partner's byte when paired
  task automatic check_image(input int base, input int len, input int grp, input int sw);
    int bad = 0;
    for (int p = 0; p < 16; p++) begin
      int q = p;
      int a = (base + p) % 256;
      if (sw != 0 && (p % 2) == grp && p + 1 < len) q = p + 1;
      else if (sw != 0 && (p % 2) != grp && p > 0) q = p - 1;
      if (p < len) begin
        if (cnt[a] != 1 || img[a] !== src[q]) bad++;
      end else if (cnt[a] != 0) bad++;
    end
    check(bad == 0, "buffer image (R10 each position once)", bad, 0);
  endtask

  task automatic run_txn(input int base, input int len, input int grp, input int sw,
                         input int n, input int gap, input bit chg);
    for (int i = 0; i < 256; i++) cnt[i] = 0;
    for (int i = 0; i < 16; i++) src[i] = 8'((base * 7 + i * 29 + 3) & 8'hFF);
    cfg_base = 8'(base); cfg_len = 4'(len); cfg_odd_grp = grp[0]; cfg_swap = sw[0];
    for (int i = 0; i < n; i++) begin
      step(i == 0, 1'b1, src[i]);
      if (chg && i == 0) begin
        cfg_base = ~cfg_base; cfg_len = 4'd1; cfg_odd_grp = ~cfg_odd_grp; cfg_swap = ~cfg_swap;
      end
      for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 8'hEE);
    end
    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    if (n >= len) check_image(base, len, grp, sw);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    req = "watchdog";
    check(1'b0, "run did not finish", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; txn_start = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
    cfg_swap = 1'b0; cfg_odd_grp = 1'b0; cfg_len = 4'd0; cfg_base = 8'h00;
    m_pos = 0; m_len = 0; m_base = 0; m_swap = 0; m_grp = 0; m_held = 0;
    for (int i = 0; i < 256; i++) begin cnt[i] = 0; img[i] = 8'h00; end
    repeat (3) @(negedge clk);
    req = "R9";
    check(buf_we === 2'b00, "enables in reset", buf_we, 0);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, 8'h00);
    // bytes before any start pulse are ignored
    req = "R9";
    cfg_len = 4'd5;
    repeat (4) step(1'b0, 1'b1, 8'hA5);

    req = "R1"; run_txn(8'h10, 6, 0, 1, 6, 0, 1'b0);
    req = "R1 R4 trailing"; run_txn(8'h20, 5, 0, 1, 5, 1, 1'b0);
    req = "R2 R4 leading"; run_txn(8'h30, 6, 1, 1, 6, 0, 1'b0);
    req = "R2"; run_txn(8'h40, 5, 1, 1, 5, 2, 1'b0);
    req = "R3"; run_txn(8'h50, 7, 0, 0, 7, 0, 1'b0);
    req = "R3 odd phase"; run_txn(8'h58, 4, 1, 0, 4, 1, 1'b0);
    req = "R5 zero count"; run_txn(8'h60, 0, 0, 1, 3, 0, 1'b0);
    req = "R5 surplus"; run_txn(8'h70, 3, 0, 1, 8, 0, 1'b0);
    req = "R8"; run_txn(8'h80, 8, 0, 1, 8, 1, 1'b1);
    req = "R7 wrap"; run_txn(8'hF8, 15, 1, 1, 15, 0, 1'b0);
    req = "R10"; run_txn(8'h90, 15, 0, 1, 15, 1, 1'b0);
    req = "R4 single"; run_txn(8'hA0, 1, 0, 1, 1, 0, 1'b0);

    // R6: restart while a byte is held, new start carries a byte
    req = "R6";
    for (int i = 0; i < 256; i++) cnt[i] = 0;
    cfg_base = 8'hB0; cfg_len = 4'd6; cfg_odd_grp = 1'b0; cfg_swap = 1'b1;
    step(1'b1, 1'b1, 8'h01);
    step(1'b0, 1'b1, 8'h02);
    step(1'b0, 1'b1, 8'h03);  // held
    for (int i = 0; i < 256; i++) cnt[i] = 0;
    for (int i = 0; i < 16; i++) src[i] = 8'(8'hC0 + i);
    cfg_base = 8'hC0; cfg_len = 4'd3; cfg_odd_grp = 1'b1;
    step(1'b1, 1'b1, src[0]);
    step(1'b0, 1'b1, src[1]);
    step(1'b0, 1'b1, src[2]);
    step(1'b0, 1'b0, 8'h00);
    check_image(8'hC0, 3, 1, 1);
    // R6: restart with no byte, pair completes from fresh bytes only
    for (int i = 0; i < 256; i++) cnt[i] = 0;
    cfg_base = 8'hD0; cfg_len = 4'd4; cfg_odd_grp = 1'b0;
    step(1'b1, 1'b1, 8'h55);  // held
    for (int i = 0; i < 256; i++) cnt[i] = 0;
    for (int i = 0; i < 16; i++) src[i] = 8'(8'hE0 + i);
    cfg_base = 8'hE0;
    step(1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, src[i]);
    step(1'b0, 1'b0, 8'h00);
    check_image(8'hE0, 4, 0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule